// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a requester and backing memory. It decodes two 32 MiB alias windows. Each 32-bit word in a window stands for one bit of a 1 MiB backing region. A read through a window fetches the backing data and returns only the addressed bit. A write fetches the backing data, forces the addressed bit to the value of write-data bit 0, and stores the result back. The fetch and the store-back form one locked pair.

Both ports use a request/response scheme. On the slave side the requester holds `s_req` and its fields steady until the bridge raises `s_ready` for one cycle. On the master side the bridge holds `m_req` and its fields steady until memory raises `m_ready` for one cycle. Backing data is carried right-justified and little-endian: lane 0 holds the byte at the lowest address.

Top module: `bitband_bridge`

## Requirements
- R1: A request hits window 0 when `s_addr[31:25]` equals that of 0x2200_0000, and window 1 when it equals that of 0x4200_0000. The backing address is the window's target (0x2000_0000 or 0x4000_0000) OR'd with `s_addr[24:0] >> 5`.
- R2: The backing address on `m_addr` is rounded down to a multiple of the access size. `m_size` equals `s_size`.
- R3: A read returns the selected bit in `s_rdata[0]`, and all other bits are zero. The bit index into the right-justified backing data is `s_addr[6:2]` masked by (8 × size − 1). Index bits [4:3] select the byte and bits [2:0] select the bit within that byte.
- R4: A write stores back the fetched data with the selected bit set when `s_wdata[0]` is 1, or cleared when it is 0. The store-back uses the same address and size as the fetch, and every other bit is unchanged.
- R5: `s_size` gives a byte count, and only 1, 2 and 4 are legal. Any other value returns `s_err` = 1 and makes no backing access.
- R6: The following requests return `s_err` = 1 and make no backing access:
  - a request while `bb_en` is 0;
  - a request whose address lies outside both windows.
- R7: If the fetch reports `m_err`, the bridge returns `s_err` = 1 and does not store back.
- R8: If the store-back reports `m_err`, the bridge returns `s_err` = 1.
- R9: `m_lock` is high during both the fetch and the store-back of a write, and low during a read. No new request is taken until the store-back completes.
- R10: After reset, `s_ready`, `m_req` and `m_lock` are 0. `s_ready` is a single-cycle pulse, raised only after the last backing access has completed. Master request fields stay stable until `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bb_en | input | 1 | Enables alias decoding |
| s_req | input | 1 | Slave request, held until s_ready |
| s_we | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Alias address |
| s_size | input | 3 | Access size in bytes |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, valid with s_ready |
| s_err | output | 1 | Error flag, valid with s_ready |
| m_req | output | 1 | Backing request |
| m_we | output | 1 | Backing write |
| m_lock | output | 1 | Locked read-modify-write in progress |
| m_addr | output | 32 | Backing byte address |
| m_size | output | 3 | Backing access size in bytes |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_ready | input | 1 | Backing completion pulse |
| m_rdata | input | 32 | Backing read data, right-justified |
| m_err | input | 1 | Backing error, valid with m_ready |

## Verification
The assertions assume the following about the inputs:
- memory raises `m_ready` only while `m_req` is high, for one cycle at a time;
- `m_err` is meaningful only alongside `m_ready`;
- the requester keeps `s_req` and its fields steady until `s_ready`.

The bench's memory model answers one cycle after it sees `m_req`, and drops `m_ready` in the cycle that follows. The bench drives each request at a falling edge and releases it at the falling edge where `s_ready` is seen. Error injection is set only between transactions, so it never changes during a backing access.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS0   = 32'h2200_0000,
  parameter logic [31:0] TARGET0  = 32'h2000_0000,
  parameter logic [31:0] ALIAS1   = 32'h4200_0000,
  parameter logic [31:0] TARGET1  = 32'h4000_0000,
  parameter int          WIN_BITS = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bb_en,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [31:0] s_addr,
  input  logic [2:0]  s_size,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        s_err,
  output logic        m_req,
  output logic        m_we,
  output logic        m_lock,
  output logic [31:0] m_addr,
  output logic [2:0]  m_size,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic [31:0] m_rdata,
  input  logic        m_err
);
  localparam int HI_W  = 32 - WIN_BITS;
  localparam int SHIFT = 5;

  typedef enum logic [1:0] {IDLE, FETCH, STORE, RESP} st_t;
  st_t st;

  logic        r_we, r_set, r_err;
  logic [2:0]  r_size;
  logic [4:0]  r_bpos;
  logic [31:0] r_maddr, r_wdat, r_rdata;

  logic        hit0, hit1, size_ok, legal;
  logic [31:0] offs, base, baddr, aligned, sel, lmask, merged;
  logic [4:0]  bmask, bpos;

  assign hit0    = s_addr[31:WIN_BITS] == ALIAS0[31:WIN_BITS];
  assign hit1    = s_addr[31:WIN_BITS] == ALIAS1[31:WIN_BITS];
  assign size_ok = (s_size == 3'd1) || (s_size == 3'd2) || (s_size == 3'd4);
  assign legal   = bb_en && (hit0 || hit1) && size_ok;

  assign offs    = {{HI_W{1'b0}}, s_addr[WIN_BITS-1:0]};
  assign base    = hit1 ? TARGET1 : TARGET0;
  assign baddr   = base | (offs >> SHIFT);
  assign aligned = baddr & ~{29'd0, s_size - 3'd1};
  assign bmask   = (s_size == 3'd1) ? 5'd7 : (s_size == 3'd2) ? 5'd15 : 5'd31;
  assign bpos    = offs[6:2] & bmask;

  assign sel     = 32'd1 << r_bpos;
  assign lmask   = (r_size == 3'd1) ? 32'h0000_00FF :
                   (r_size == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign merged  = (r_set ? (m_rdata | sel) : (m_rdata & ~sel)) & lmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      r_we    <= 1'b0;
      r_set   <= 1'b0;
      r_err   <= 1'b0;
      r_size  <= 3'd0;
      r_bpos  <= 5'd0;
      r_maddr <= 32'd0;
      r_wdat  <= 32'd0;
      r_rdata <= 32'd0;
    end else begin
      case (st)
        IDLE: if (s_req) begin
          r_we    <= s_we;
          r_set   <= s_wdata[0];
          r_size  <= s_size;
          r_bpos  <= bpos;
          r_maddr <= aligned;
          r_rdata <= 32'd0;
          r_err   <= !legal;
          st      <= legal ? FETCH : RESP;
        end
        FETCH: if (m_ready) begin
          if (m_err) begin
            r_err <= 1'b1;
            st    <= RESP;
          end else if (r_we) begin
            r_wdat <= merged;
            st     <= STORE;
          end else begin
            r_rdata <= {31'd0, m_rdata[r_bpos]};
            st      <= RESP;
          end
        end
        STORE: if (m_ready) begin
          r_err <= m_err;
          st    <= RESP;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign s_ready = st == RESP;
  assign s_rdata = r_rdata;
  assign s_err   = r_err;
  assign m_req   = (st == FETCH) || (st == STORE);
  assign m_we    = st == STORE;
  assign m_lock  = m_req && r_we;
  assign m_addr  = r_maddr;
  assign m_size  = r_size;
  assign m_wdata = r_wdat;

  logic unused_bits;
  assign unused_bits = ^s_wdata[31:1];
endmodule

module bitband_bridge_chk #(
  parameter logic [31:0] TARGET0 = 32'h2000_0000,
  parameter logic [31:0] TARGET1 = 32'h4000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_ready,
  input logic        s_err,
  input logic [31:0] s_rdata,
  input logic        m_req,
  input logic        m_we,
  input logic        m_lock,
  input logic        m_ready,
  input logic        m_err,
  input logic [31:0] m_addr,
  input logic [2:0]  m_size
);
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_size)));

  a_r9_lock_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    m_lock |-> m_req);

  a_r9_lock_to_store: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_ready && !m_we && !m_err) |=> (m_req && m_we && m_lock));

  a_r5_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_size == 3'd1 || m_size == 3'd2 || m_size == 3'd4));

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ((m_addr & {29'd0, m_size - 3'd1}) == 32'd0));

  a_r1_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_addr[31:20] == TARGET0[31:20] || m_addr[31:20] == TARGET1[31:20]));

  a_r7_no_store_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ready && m_err && !m_we) |=> !m_req);

  a_r8_store_err_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && m_ready && m_err) |=> (s_ready && s_err));

  a_r3_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_rdata[31:1] == 31'd0));
endmodule

bind bitband_bridge bitband_bridge_chk #(.TARGET0(TARGET0), .TARGET1(TARGET1)) u_chk (.*);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bb_en = 1'b0;
  logic        s_req = 1'b0, s_we = 1'b0;
  logic [31:0] s_addr = 32'd0, s_wdata = 32'd0;
  logic [2:0]  s_size = 3'd0;
  logic        s_ready, s_err;
  logic [31:0] s_rdata;
  logic        m_req, m_we, m_lock;
  logic [31:0] m_addr, m_wdata;
  logic [2:0]  m_size;
  logic        m_ready, m_err;
  logic [31:0] m_rdata;

  always #2 clk = ~clk;

  bitband_bridge u_bitband_bridge (.*);

  logic [7:0]  mem0 [256];
  logic [7:0]  mem1 [256];
  logic        err_rd = 1'b0, err_wr = 1'b0;
  int          acc_cnt, lock_cnt;
  logic [31:0] last_maddr;

  function automatic logic [31:0] mread(input logic [31:0] a, input logic [2:0] sz);
    logic [31:0] v = 32'd0;
    for (int i = 0; i < 4; i++)
      if (i < int'(sz))
        v[8*i +: 8] = a[30] ? mem1[a[7:0] + 8'(i)] : mem0[a[7:0] + 8'(i)];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready <= 1'b0; m_err <= 1'b0; m_rdata <= 32'd0;
      acc_cnt <= 0; lock_cnt <= 0; last_maddr <= 32'd0;
      for (int k = 0; k < 256; k++) begin mem0[k] <= 8'(k); mem1[k] <= 8'd0; end
    end else if (m_req && !m_ready) begin
      m_ready    <= 1'b1;
      acc_cnt    <= acc_cnt + 1;
      lock_cnt   <= lock_cnt + (m_lock ? 1 : 0);
      last_maddr <= m_addr;
      if (m_we) begin
        m_err <= err_wr; m_rdata <= 32'd0;
        if (!err_wr)
          for (int i = 0; i < 4; i++)
            if (i < int'(m_size)) begin
              if (m_addr[30]) mem1[m_addr[7:0] + 8'(i)] <= m_wdata[8*i +: 8];
              else            mem0[m_addr[7:0] + 8'(i)] <= m_wdata[8*i +: 8];
            end
      end else begin
        m_err <= err_rd; m_rdata <= mread(m_addr, m_size);
      end
    end else begin
      m_ready <= 1'b0; m_err <= 1'b0;
    end
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] x_rd, x_maddr;
  logic        x_err;
  int          x_n, x_lk;

  task automatic xfer(input logic we, input logic [31:0] addr, input logic [2:0] sz,
                      input logic [31:0] wd);
    int a0 = acc_cnt, l0 = lock_cnt, w = 0;
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_addr = addr; s_size = sz; s_wdata = wd;
    do begin @(negedge clk); w++; end while (!s_ready && w < 60);
    if (!s_ready) chk("R10 timeout", 32'd0, 32'd1);
    x_rd = s_rdata; x_err = s_err; x_maddr = last_maddr;
    x_n = acc_cnt - a0; x_lk = lock_cnt - l0;
    s_req = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic        err;
    logic [31:0] maddr;
    logic [1:0]  n;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h2200_0060, 3'd1, 32'h0, 32'h1, 1'b0, 32'h2000_0003, 2'd1},
    '{1'b0, 32'h2200_0068, 3'd1, 32'h0, 32'h0, 1'b0, 32'h2000_0003, 2'd1},
    '{1'b0, 32'h2200_00A8, 3'd4, 32'h0, 32'h1, 1'b0, 32'h2000_0004, 2'd1},
    '{1'b0, 32'h2200_00C4, 3'd2, 32'h0, 32'h1, 1'b0, 32'h2000_0006, 2'd1},
    '{1'b0, 32'h2200_00EC, 3'd2, 32'h0, 32'h0, 1'b0, 32'h2000_0006, 2'd1},
    '{1'b1, 32'h4200_0054, 3'd1, 32'h1, 32'h0, 1'b0, 32'h4000_0002, 2'd2},
    '{1'b0, 32'h4200_0054, 3'd1, 32'h0, 32'h1, 1'b0, 32'h4000_0002, 2'd1},
    '{1'b1, 32'h4200_0054, 3'd4, 32'hFFFF_FFFE, 32'h0, 1'b0, 32'h4000_0000, 2'd2},
    '{1'b0, 32'h4200_0054, 3'd2, 32'h0, 32'h0, 1'b0, 32'h4000_0002, 2'd1},
    '{1'b1, 32'h2200_023C, 3'd4, 32'h1, 32'h0, 1'b0, 32'h2000_0010, 2'd2},
    '{1'b0, 32'h2200_023C, 3'd1, 32'h0, 32'h1, 1'b0, 32'h2000_0011, 2'd1},
    '{1'b0, 32'h23FF_FFFC, 3'd1, 32'h0, 32'h1, 1'b0, 32'h200F_FFFF, 2'd1},
    '{1'b0, 32'h23FF_FFFC, 3'd4, 32'h0, 32'h1, 1'b0, 32'h200F_FFFC, 2'd1},
    '{1'b0, 32'h2200_0000, 3'd3, 32'h0, 32'h0, 1'b1, 32'h0, 2'd0},
    '{1'b0, 32'h2400_0000, 3'd1, 32'h0, 32'h0, 1'b1, 32'h0, 2'd0},
    '{1'b1, 32'h2200_0000, 3'd0, 32'h1, 32'h0, 1'b1, 32'h0, 2'd0},
    '{1'b0, 32'h2200_0001, 3'd1, 32'h0, 32'h0, 1'b0, 32'h2000_0000, 2'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset s_ready", 32'(s_ready), 32'd0);
    chk("R10 reset m_req", 32'(m_req), 32'd0);
    chk("R9 reset m_lock", 32'(m_lock), 32'd0);

    xfer(1'b0, 32'h2200_0060, 3'd1, 32'h0);
    chk("R6 disabled err", 32'(x_err), 32'd1);
    chk("R6 disabled no access", 32'(x_n), 32'd0);
    bb_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v].we, VEC[v].addr, VEC[v].size, VEC[v].wdata);
      chk($sformatf("R5/R6 row %0d err", v), 32'(x_err), 32'(VEC[v].err));
      chk($sformatf("R3 row %0d rdata", v), x_rd, VEC[v].rd);
      chk($sformatf("R5 row %0d accesses", v), 32'(x_n), 32'(VEC[v].n));
      if (VEC[v].n != 2'd0)
        chk($sformatf("R1/R2 row %0d maddr", v), x_maddr, VEC[v].maddr);
      chk($sformatf("R9 row %0d locked accesses", v), 32'(x_lk),
          (VEC[v].we && !VEC[v].err) ? 32'd2 : 32'd0);
    end

    chk("R4 set bit byte 17", 32'(mem0[17]), 32'h91);
    chk("R4 neighbour byte 16", 32'(mem0[16]), 32'h10);
    chk("R4 neighbour byte 19", 32'(mem0[19]), 32'h13);
    chk("R4 cleared byte", 32'(mem1[2]), 32'h00);

    @(negedge clk);
    chk("R10 ready is one pulse", 32'(s_ready), 32'd0);

    err_rd = 1'b1;
    xfer(1'b1, 32'h2200_0064, 3'd1, 32'h1);
    err_rd = 1'b0;
    chk("R7 fetch err", 32'(x_err), 32'd1);
    chk("R7 no store-back", 32'(x_n), 32'd1);
    chk("R7 memory unchanged", 32'(mem0[3]), 32'h03);

    err_wr = 1'b1;
    xfer(1'b1, 32'h2200_0064, 3'd1, 32'h1);
    err_wr = 1'b0;
    chk("R8 store err", 32'(x_err), 32'd1);
    chk("R8 both accesses", 32'(x_n), 32'd2);

    xfer(1'b1, 32'h2200_0064, 3'd1, 32'h1);
    chk("R4 set bit1 byte 3", 32'(mem0[3]), 32'h03);
    xfer(1'b1, 32'h2200_0060, 3'd2, 32'h0);
    chk("R4 clear bit0 byte 3", 32'(mem0[3]), 32'h02);
    chk("R2 half aligned", x_maddr, 32'h2000_0002);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule